// File: doc/BRIEF.md
# Multi-Chip Word Memory with Set Decoding

This block builds one memory out of a grid of identical narrow storage chips. The chips are grouped into sets, and the data pins of one set together span the full access width. The bus is addressed in small units such as bytes, while every access moves a whole word. The address splits into three fields. The top bits pick the set. The middle bits go to the address pins of every chip. The bottom bits, which index a unit inside a word, are dropped.

The geometry comes from a few parameters: memory size in addressable units, unit width, access width, chip depth and chip width. From these the block derives the chip count, the chips per set and the set count. Chips per set is the access width over the chip width, and the set count is the chip count over the chips per set. Geometry that is not valid stops elaboration with a fatal error. This covers an access narrower than the unit, widths that do not divide evenly, and address fields that do not add up to the address width. As an example, 128 MB of byte-addressed storage with 32-bit access, built from 8M x 8 chips, gives 16 chips in 4 sets of 4. The default is a 256-unit memory of 16 x 8 chips with 32-bit access, which gives the same 4 x 4 grid.

The host drives a read enable and a write enable and has no chip select. Chip i of a set carries data bits [i*CHIP_W +: CHIP_W]. Read data is registered inside the chips, so it appears one clock after the read.

Top module: `multi_chip_mem`

## Requirements
- R1: While reset is held and after it is released, read data is zero until the first read completes.
- R2: A read at enable code re=1, we=0 returns, on the clock edge after the read, the word most recently written to that word address with re=0, we=1, for every word of the memory.
- R3: The top log2(sets) address bits choose the set. On a read or write exactly one set receives a chip select, and it is the set those bits name. On any other cycle no set is selected. A write to one set leaves the words at the same chip offset in every other set unchanged.
- R4: With an access 2^k units wide, the k least significant address bits are ignored. Any unit address inside a word reaches the same stored word, and the neighbouring words are untouched.
- R5: With both enables low nothing is written, and the read data output holds its previous value.
- R6: With both enables high (an illegal code) nothing is written, and the read data output holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| re_i | input | 1 | Read enable |
| we_i | input | 1 | Write enable |
| addr_i | input | ADDR_W | Unit address: set field on top, chip offset in the middle, ignored unit index at the bottom |
| din_i | input | ACC_W | Write data |
| dout_o | output | ACC_W | Read data, valid one clock after a read |

## Verification
The bench fills every word and reads all of them back through a reference array. A set decoder that swapped or merged sets would alias two words. A data slice put on the wrong chip would return scrambled bytes. The bench writes and reads at every low-bit offset inside a word, so a design that kept the unit index in the chip address would miss the word or hit its neighbour. The idle and illegal enable codes are driven with fresh data on the bus and then read back. A design that wrote on either code would corrupt the word, and one that reloaded the output would break the hold.

// File: rtl/mc_geom_pkg.sv
package mc_geom_pkg;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_BAD   = 2'd3
   } acc_kind_e;

   function automatic acc_kind_e classify(input logic rd, input logic wr);
      case ({rd, wr})
         2'b10:   return ACC_READ;
         2'b01:   return ACC_WRITE;
         2'b11:   return ACC_BAD;
         default: return ACC_IDLE;
      endcase
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/mc_chip.sv
module mc_chip #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cs_i,
   input  logic          re_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [W-1:0]  din_i,
   output logic [W-1:0]  dout_o
);

   logic [W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (cs_i && we_i) cells[addr_i] <= din_i;
   end

   always_ff @(posedge clk) begin
      if (rst)               dout_o <= '0;
      else if (cs_i && re_i) dout_o <= cells[addr_i];
   end

endmodule

// File: rtl/mc_set_decode.sv
module mc_set_decode #(
   parameter int N_SETS = 4,
   parameter int SEL_W  = 2
) (
   input  logic              en_i,
   input  logic [SEL_W-1:0]  idx_i,
   output logic [N_SETS-1:0] cs_o
);

   for (genvar g = 0; g < N_SETS; g++) begin : g_sel
      assign cs_o[g] = en_i && (idx_i == SEL_W'(g));
   end

endmodule

// File: rtl/multi_chip_mem.sv
module multi_chip_mem
   import mc_geom_pkg::*;
#(
   parameter int MEM_UNITS  = 256,
   parameter int UNIT_W     = 8,
   parameter int ACC_W      = 32,
   parameter int CHIP_DEPTH = 16,
   parameter int CHIP_W     = 8,
   localparam int ADDR_W    = $clog2(MEM_UNITS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              re_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ACC_W-1:0]  din_i,
   output logic [ACC_W-1:0]  dout_o
);

   localparam int TOTAL_BITS = MEM_UNITS * UNIT_W;
   localparam int CHIP_BITS  = CHIP_DEPTH * CHIP_W;
   localparam int N_CHIPS    = TOTAL_BITS / CHIP_BITS;
   localparam int PER_SET    = (ACC_W >= CHIP_W) ? ACC_W / CHIP_W : 1;
   localparam int N_SETS     = (N_CHIPS >= PER_SET && N_CHIPS > 0) ? N_CHIPS / PER_SET : 1;
   localparam int UNITS_WORD = (ACC_W >= UNIT_W) ? ACC_W / UNIT_W : 1;
   localparam int DROP_W     = $clog2(UNITS_WORD);
   localparam int CHIP_AW    = (CHIP_DEPTH > 1) ? $clog2(CHIP_DEPTH) : 1;
   localparam int SET_BITS   = $clog2(N_SETS);
   localparam int SET_SEL_W  = (SET_BITS > 0) ? SET_BITS : 1;

   // elaboration-time geometry checks
   if (ACC_W < UNIT_W) begin : g_bad_acc
      $fatal(1, "access width narrower than addressable unit");
   end
   if (!is_pow2(UNITS_WORD) || (ACC_W % UNIT_W) != 0) begin : g_bad_units
      $fatal(1, "access width must be a power-of-two multiple of the unit");
   end
   if ((ACC_W % CHIP_W) != 0 || ACC_W < CHIP_W) begin : g_bad_slice
      $fatal(1, "access width must be a multiple of chip width");
   end
   if ((TOTAL_BITS % CHIP_BITS) != 0 || (N_CHIPS % PER_SET) != 0) begin : g_bad_count
      $fatal(1, "chip count does not fill whole sets");
   end
   if (!is_pow2(MEM_UNITS) || !is_pow2(CHIP_DEPTH) || !is_pow2(N_SETS)) begin : g_bad_pow2
      $fatal(1, "memory size, chip depth and set count must be powers of two");
   end
   if (DROP_W + $clog2(CHIP_DEPTH) + SET_BITS != ADDR_W) begin : g_bad_split
      $fatal(1, "address fields do not cover the address width");
   end

   acc_kind_e kind;
   logic      do_rd, do_wr, do_any;

   assign kind   = classify(re_i, we_i);
   assign do_rd  = (kind == ACC_READ);
   assign do_wr  = (kind == ACC_WRITE);
   assign do_any = do_rd || do_wr;

   logic [CHIP_AW-1:0]   chip_addr;
   logic [SET_SEL_W-1:0] set_idx;
   logic [SET_SEL_W-1:0] rd_set_q;
   logic [N_SETS-1:0]    set_cs;

   if (CHIP_DEPTH > 1) begin : g_caddr
      assign chip_addr = addr_i[DROP_W +: CHIP_AW];
   end else begin : g_caddr_one
      assign chip_addr = '0;
   end

   if (N_SETS > 1) begin : g_multi_set
      assign set_idx = addr_i[ADDR_W-1 -: SET_BITS];
   end else begin : g_single_set
      assign set_idx = '0;
   end

   mc_set_decode #(
      .N_SETS (N_SETS),
      .SEL_W  (SET_SEL_W)
   ) u_dec (
      .en_i  (do_any),
      .idx_i (set_idx),
      .cs_o  (set_cs)
   );

   always_ff @(posedge clk) begin
      if (rst)        rd_set_q <= '0;
      else if (do_rd) rd_set_q <= set_idx;
   end

   logic [N_SETS-1:0][ACC_W-1:0] set_word;

   for (genvar s = 0; s < N_SETS; s++) begin : g_set
      for (genvar c = 0; c < PER_SET; c++) begin : g_chip
         mc_chip #(
            .DEPTH (CHIP_DEPTH),
            .W     (CHIP_W)
         ) u_chip (
            .clk    (clk),
            .rst    (rst),
            .cs_i   (set_cs[s]),
            .re_i   (do_rd),
            .we_i   (do_wr),
            .addr_i (chip_addr),
            .din_i  (din_i[c*CHIP_W +: CHIP_W]),
            .dout_o (set_word[s][c*CHIP_W +: CHIP_W])
         );
      end
   end

   assign dout_o = set_word[rd_set_q];

endmodule

// File: rtl/mc_mem_checker.sv
module mc_mem_checker #(
   parameter int ADDR_W = 8,
   parameter int ACC_W  = 32,
   parameter int N_SETS = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              re_i,
   input logic              we_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [ACC_W-1:0]  dout_o,
   input logic [N_SETS-1:0] set_cs
);

   localparam int SET_BITS = $clog2(N_SETS);

   logic [31:0] want_set;
   assign want_set = 32'(addr_i >> (ADDR_W - SET_BITS));

   p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!re_i && !we_i) |=> $stable(dout_o));

   p_both_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (re_i && we_i) |=> $stable(dout_o));

   p_cs_onehot_r3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(set_cs));

   p_cs_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      !(re_i ^ we_i) |-> (set_cs == '0));

   p_cs_target_r3: assert property (@(posedge clk) disable iff (rst)
      (re_i ^ we_i) |-> ($countones(set_cs) == 1 && set_cs[want_set]));

endmodule

bind multi_chip_mem mc_mem_checker #(
   .ADDR_W (ADDR_W),
   .ACC_W  (ACC_W),
   .N_SETS (N_SETS)
) u_mc_chk (
   .clk    (clk),
   .rst    (rst),
   .re_i   (re_i),
   .we_i   (we_i),
   .addr_i (addr_i),
   .dout_o (dout_o),
   .set_cs (set_cs)
);

// File: tb/tb_multi_chip_mem.sv
module tb_multi_chip_mem;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 8;
   localparam int DW         = 32;
   localparam int NWORDS     = 64;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          re  = 1'b0;
   logic          we  = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din  = '0;
   logic [DW-1:0] dout;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   logic [DW-1:0] ref_mem [NWORDS];
   logic [DW-1:0] last_rd = '0;

   typedef struct {
      logic [DW-1:0] exp;
      int            due;
      string         tag;
   } sb_item_t;

   sb_item_t sb_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   multi_chip_mem dut (
      .clk    (clk),
      .rst    (rst),
      .re_i   (re),
      .we_i   (we),
      .addr_i (addr),
      .din_i  (din),
      .dout_o (dout)
   );

   function automatic logic [DW-1:0] pat(input int w, input int salt);
      return {8'(w * 7 + salt), 8'(~w), 8'(w ^ salt), 8'(8'hA5 + w)};
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // monitor: pop scoreboard items when they fall due
   always @(negedge clk) begin
      if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
         sb_item_t it;
         it = sb_q.pop_front();
         check(it.tag, dout, it.exp);
      end
   end

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      re = 1'b0; we = 1'b1; addr = AW'(a); din = d;
      ref_mem[(a >> 2) % NWORDS] = d;
   endtask

   task automatic rd(input int a, input string tag);
      sb_item_t it;
      @(negedge clk);
      re = 1'b1; we = 1'b0; addr = AW'(a); din = '0;
      last_rd = ref_mem[(a >> 2) % NWORDS];
      it.exp = last_rd; it.due = cyc + 1; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic hold(input logic r, input logic w, input int a, input logic [DW-1:0] d,
                       input string tag);
      sb_item_t it;
      @(negedge clk);
      re = r; we = w; addr = AW'(a); din = d;
      it.exp = last_rd; it.due = cyc + 1; it.tag = tag;
      sb_q.push_back(it);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      total++; bad++;
      $display("FAIL watchdog R2: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 in reset", dout, '0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 after reset", dout, '0);

      // fill every word, varying the ignored low bits
      for (int w = 0; w < NWORDS; w++) wr(w * 4 + ((w >> 1) & 3), pat(w, 17));
      // read every word back, again at varied low bits
      for (int w = 0; w < NWORDS; w++) rd(w * 4 + (w & 3), "R2 fill readback");

      // R4: low unit bits ignored
      wr(8'h41, 32'hDEAD_BEEF);
      rd(8'h43, "R4 same word other offset");
      rd(8'h40, "R4 same word offset 0");
      rd(8'h3F, "R4 lower neighbour");
      rd(8'h44, "R4 upper neighbour");

      // R3: set isolation at same chip offset
      wr(8'h0E, 32'h1234_5678);
      rd(8'h0C, "R3 written set");
      rd(8'h4C, "R3 set 1 same offset");
      rd(8'h8D, "R3 set 2 same offset");
      rd(8'hCF, "R3 set 3 same offset");

      // R5: idle code holds output and writes nothing
      rd(5 * 4, "R5 prime read");
      hold(1'b0, 1'b0, 5 * 4, 32'hFFFF_0000, "R5 idle hold");
      hold(1'b0, 1'b0, 5 * 4, 32'h0F0F_0F0F, "R5 idle hold again");
      rd(5 * 4, "R5 no write on idle");

      // R6: illegal code holds output and writes nothing
      rd(9 * 4, "R6 prime read");
      hold(1'b1, 1'b1, 9 * 4, 32'hCAFE_F00D, "R6 illegal hold");
      hold(1'b1, 1'b1, 40 * 4, 32'h0BAD_0BAD, "R6 illegal hold other set");
      rd(9 * 4, "R6 no write on illegal");
      rd(40 * 4, "R6 other set untouched");

      // R2: back-to-back reads across all sets, one-cycle latency
      rd(63 * 4, "R2 last word");
      rd(0, "R2 first word");
      rd(32 * 4 + 2, "R2 set 2 word");

      hold(1'b0, 1'b0, 0, '0, "R5 final idle");
      repeat (4) @(negedge clk);
      if (sb_q.size() != 0) begin
         total++; bad++;
         $display("FAIL R2: got %0d pending expected 0", sb_q.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule